// File: doc/BRIEF.md
# Three-Tap Code Tracking Correlator Channel

One tracking channel of a spread-spectrum receiver. Decimated baseband I/Q samples arrive one per valid cycle, with a marker on the first sample of each one-millisecond block and a timestamp for that block. A carrier phase accumulator removes the residual carrier by quarter-turn rotation. A code phase accumulator then indexes a host-loaded chip sequence at three offsets: early, prompt and late, half a chip apart. Six signed sums, I and Q for each tap, build up sample by sample.

On each block marker the sums of the block just finished go into a small record FIFO, together with that block's timestamp. The sums restart with the marker sample itself. A host pops the records, runs the loop filters in software, and writes new carrier and code rate words. Those words are held as pending and only become active on the next block marker, so a block never mixes two rates. Every programmable number of blocks the channel also emits the current carrier and code phases as a measurement. Each input sample is passed on unchanged one cycle later, so channels can be chained on one stream.

Top module: `tc_track_chan`

## Requirements
- R1: While reset is held and in the first cycle after it, dump_empty is 1, fwd_valid is 0 and meas_valid is 0. Code phase, carrier phase, rate words, sums and the measurement interval all start at zero.
- R2: Every input cycle appears on the fwd_* outputs one clock later with identical valid, marker, stamp, I and Q values.
- R3: Writing address 2 shifts wr_data[0] into the chip register. After CODE_LEN such writes, chip k is the k-th bit written, counting from 0. Chip 0 multiplies by +1 and chip 1 by -1. The prompt chip index is floor(code_phase / 2^FRAC_W). Each valid sample advances code_phase by the active code rate, modulo CODE_LEN·2^FRAC_W.
- R4: The early tap uses the chip at code_phase + 2^(FRAC_W-1) and the late tap the chip at code_phase - 2^(FRAC_W-1), both wrapped modulo CODE_LEN·2^FRAC_W.
- R5: The top two bits of carrier_phase select the rotation of (i,q): 0 gives (i,q), 1 gives (q,-i), 2 gives (-i,-q), 3 gives (-q,i). Each valid sample advances carrier_phase by the active carrier rate, modulo 2^CW.
- R6: Every valid marker sample except the first after reset pushes one record. The record holds the previous block's six sums (early, prompt and late, I then Q) and the stamp that came with that block's marker sample. The marker sample's own products start the new sums.
- R7: Writes to address 0 (carrier rate) and address 1 (code rate) are held as pending. The phase steps taken from the next valid marker sample onwards use the new value. The marker sample correlates at the phase it already has.
- R8: The record FIFO holds FIFO_DEPTH records in order. The oldest record is shown on the dump_* outputs while dump_empty is 0, and dump_rd pops it. A record produced while the FIFO is full is dropped.
- R9: Address 3 sets the measurement interval N and clears the block count. On every N-th valid marker sample after that, meas_valid pulses for one cycle, one clock later, with the carrier and code phases held before that sample's step. N = 0 produces no measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_blk | input | 1 | First sample of a block |
| in_stamp | input | TSW | Block timestamp |
| in_i | input | SW | In-phase sample, signed |
| in_q | input | SW | Quadrature sample, signed |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | DW | Host write data |
| fwd_valid | output | 1 | Forwarded valid |
| fwd_blk | output | 1 | Forwarded block marker |
| fwd_stamp | output | TSW | Forwarded stamp |
| fwd_i | output | SW | Forwarded I sample |
| fwd_q | output | SW | Forwarded Q sample |
| dump_rd | input | 1 | Pop the oldest record |
| dump_empty | output | 1 | Record FIFO empty |
| dump_stamp | output | TSW | Record block stamp |
| dump_ei | output | ACC_W | Early I sum |
| dump_eq | output | ACC_W | Early Q sum |
| dump_pi | output | ACC_W | Prompt I sum |
| dump_pq | output | ACC_W | Prompt Q sum |
| dump_li | output | ACC_W | Late I sum |
| dump_lq | output | ACC_W | Late Q sum |
| meas_valid | output | 1 | Phase measurement strobe |
| meas_carr | output | CW | Carrier phase measurement |
| meas_code | output | clog2(CODE_LEN)+FRAC_W | Code phase measurement |

## Verification
The sums are driven four ways. A stream that copies the prompt replica must give a prompt peak, and it separates the early and late offsets from prompt. An extreme constant stream (-8, +7) exposes sign and negation errors in the chip multiply and in the rotation. Pseudo-random samples under a quarter-turn-per-sample carrier step through all four rotation cases. Rate writes placed in the middle of a block, and a fractional code rate, show whether the pending words wait for the boundary and whether the wrap arithmetic is right. Further runs of blocks without reads, and with changed measurement intervals, show the record dropping policy and the measurement cadence.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    WA_CARR = 3'd0,
    WA_CODE = 3'd1,
    WA_CHIP = 3'd2,
    WA_MEAS = 3'd3
  } wr_addr_e;

  localparam int NTAP = 3;
endpackage

// File: rtl/tc_fifo.sv
module tc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] data_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = AW + 1;

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            full, do_push, do_pop;

  assign full    = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  // R8: a record arriving at a full FIFO leaves it full and untouched
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> (full && wptr_q == $past(wptr_q)));
endmodule

// File: rtl/tc_code_gen.sv
module tc_code_gen #(
  parameter int CODE_LEN = 1023,
  parameter int FRAC_W   = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                step_i,
  input  logic                                load_i,
  input  logic [$clog2(CODE_LEN)+FRAC_W-1:0]  rate_i,
  input  logic                                chip_we_i,
  input  logic                                chip_bit_i,
  output logic [$clog2(CODE_LEN)+FRAC_W-1:0]  phase_o,
  output logic [tc_pkg::NTAP-1:0]             taps_o
);
  localparam int IW = $clog2(CODE_LEN);
  localparam int PW = IW + FRAC_W;
  localparam logic [PW:0] LIM  = (PW+1)'(CODE_LEN * (2 ** FRAC_W));
  localparam logic [PW:0] HALF = (PW+1)'(2 ** (FRAC_W - 1));

  logic [PW-1:0]       phase_q, phase_d, rate_q, rate_d, rate_use;
  logic [CODE_LEN-1:0] code_q, code_d;
  logic [PW:0]         sum, e_sum, e_ph, l_ph, p_ext;
  logic [IW-1:0]       e_idx, p_idx, l_idx;

  always_comb begin
    rate_use = load_i ? rate_i : rate_q;
    p_ext    = {1'b0, phase_q};
    sum      = p_ext + {1'b0, rate_use};
    e_sum    = p_ext + HALF;
    e_ph     = (e_sum >= LIM) ? e_sum - LIM : e_sum;
    l_ph     = (p_ext >= HALF) ? p_ext - HALF : p_ext + LIM - HALF;
    e_idx    = IW'(e_ph >> FRAC_W);
    p_idx    = IW'(p_ext >> FRAC_W);
    l_idx    = IW'(l_ph >> FRAC_W);
    phase_d  = phase_q;
    rate_d   = rate_q;
    code_d   = code_q;
    if (load_i)    rate_d  = rate_i;
    if (step_i)    phase_d = (sum >= LIM) ? PW'(sum - LIM) : PW'(sum);
    if (chip_we_i) code_d  = {chip_bit_i, code_q[CODE_LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      rate_q  <= '0;
      code_q  <= '0;
    end else begin
      phase_q <= phase_d;
      rate_q  <= rate_d;
      code_q  <= code_d;
    end
  end

  assign phase_o   = phase_q;
  assign taps_o[0] = code_q[e_idx];
  assign taps_o[1] = code_q[p_idx];
  assign taps_o[2] = code_q[l_idx];

  // R3: the code phase never leaves one code period
  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, phase_q} < LIM);
  // R7: the active code rate moves only on a block marker
  p_rate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(rate_q));
endmodule

// File: rtl/tc_carrier.sv
module tc_carrier #(
  parameter int CW = 16,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic                 load_i,
  input  logic [CW-1:0]        rate_i,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic [CW-1:0]        phase_o,
  output logic signed [SW:0]   rot_i_o,
  output logic signed [SW:0]   rot_q_o
);
  logic [CW-1:0]      phase_q, phase_d, rate_q, rate_d;
  logic signed [SW:0] xi, xq;

  assign xi = (SW+1)'(in_i);
  assign xq = (SW+1)'(in_q);

  always_comb begin
    rate_d  = load_i ? rate_i : rate_q;
    phase_d = step_i ? phase_q + rate_d : phase_q;
    case (phase_q[CW-1 -: 2])
      2'd0:    begin rot_i_o = xi;  rot_q_o = xq;  end
      2'd1:    begin rot_i_o = xq;  rot_q_o = -xi; end
      2'd2:    begin rot_i_o = -xi; rot_q_o = -xq; end
      default: begin rot_i_o = -xq; rot_q_o = xi;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      rate_q  <= '0;
    end else begin
      phase_q <= phase_d;
      rate_q  <= rate_d;
    end
  end

  assign phase_o = phase_q;

  // R7: the active carrier rate moves only on a block marker
  p_carr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(rate_q));
endmodule

// File: rtl/tc_track_chan.sv
module tc_track_chan #(
  parameter int SW         = 4,
  parameter int TSW        = 16,
  parameter int ACC_W      = 16,
  parameter int CODE_LEN   = 1023,
  parameter int FRAC_W     = 8,
  parameter int CW         = 16,
  parameter int MW         = 16,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic                                in_blk,
  input  logic [TSW-1:0]                      in_stamp,
  input  logic signed [SW-1:0]                in_i,
  input  logic signed [SW-1:0]                in_q,
  input  logic                                wr_en,
  input  logic [2:0]                          wr_addr,
  input  logic [DW-1:0]                       wr_data,
  output logic                                fwd_valid,
  output logic                                fwd_blk,
  output logic [TSW-1:0]                      fwd_stamp,
  output logic signed [SW-1:0]                fwd_i,
  output logic signed [SW-1:0]                fwd_q,
  input  logic                                dump_rd,
  output logic                                dump_empty,
  output logic [TSW-1:0]                      dump_stamp,
  output logic signed [ACC_W-1:0]             dump_ei,
  output logic signed [ACC_W-1:0]             dump_eq,
  output logic signed [ACC_W-1:0]             dump_pi,
  output logic signed [ACC_W-1:0]             dump_pq,
  output logic signed [ACC_W-1:0]             dump_li,
  output logic signed [ACC_W-1:0]             dump_lq,
  output logic                                meas_valid,
  output logic [CW-1:0]                       meas_carr,
  output logic [$clog2(CODE_LEN)+FRAC_W-1:0]  meas_code
);
  import tc_pkg::*;

  localparam int PW   = $clog2(CODE_LEN) + FRAC_W;
  localparam int NACC = 2 * NTAP;
  localparam int RECW = TSW + NACC * ACC_W;

  logic            blk_go, push, armed_q, armed_d, meas_hit;
  logic [CW-1:0]   carr_pend_q, carr_pend_d, carr_phase;
  logic [PW-1:0]   code_pend_q, code_pend_d, code_phase;
  logic [MW-1:0]   meas_n_q, meas_n_d, meas_cnt_q, meas_cnt_d;
  logic [TSW-1:0]  bstamp_q, bstamp_d;
  logic [NTAP-1:0] taps;
  logic signed [SW:0]      rot_i, rot_q;
  logic signed [ACC_W-1:0] ext_i, ext_q;
  logic signed [ACC_W-1:0] prod [NACC];
  logic signed [ACC_W-1:0] acc_q [NACC];
  logic signed [ACC_W-1:0] acc_d [NACC];
  logic [RECW-1:0] rec_in, rec_out;

  assign blk_go = in_valid && in_blk;
  assign push   = blk_go && armed_q;

  // host registers and measurement pacing
  always_comb begin
    carr_pend_d = carr_pend_q;
    code_pend_d = code_pend_q;
    meas_n_d    = meas_n_q;
    meas_cnt_d  = meas_cnt_q;
    meas_hit    = blk_go && (meas_n_q != '0) &&
                  (({1'b0, meas_cnt_q} + 1'b1) >= {1'b0, meas_n_q});
    if (blk_go && meas_n_q != '0) meas_cnt_d = meas_hit ? '0 : meas_cnt_q + 1'b1;
    if (wr_en) begin
      case (wr_addr)
        WA_CARR: carr_pend_d = wr_data[CW-1:0];
        WA_CODE: code_pend_d = wr_data[PW-1:0];
        WA_MEAS: begin meas_n_d = wr_data[MW-1:0]; meas_cnt_d = '0; end
        default: ;
      endcase
    end
    armed_d  = armed_q || blk_go;
    bstamp_d = blk_go ? in_stamp : bstamp_q;
  end

  tc_code_gen #(.CODE_LEN(CODE_LEN), .FRAC_W(FRAC_W)) u_code (
    .clk(clk), .rst_n(rst_n), .step_i(in_valid), .load_i(blk_go),
    .rate_i(code_pend_q), .chip_we_i(wr_en && wr_addr == WA_CHIP),
    .chip_bit_i(wr_data[0]), .phase_o(code_phase), .taps_o(taps));

  tc_carrier #(.CW(CW), .SW(SW)) u_carr (
    .clk(clk), .rst_n(rst_n), .step_i(in_valid), .load_i(blk_go),
    .rate_i(carr_pend_q), .in_i(in_i), .in_q(in_q),
    .phase_o(carr_phase), .rot_i_o(rot_i), .rot_q_o(rot_q));

  assign ext_i = ACC_W'(rot_i);
  assign ext_q = ACC_W'(rot_q);

  generate
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
      assign prod[2*t]   = taps[t] ? -ext_i : ext_i;
      assign prod[2*t+1] = taps[t] ? -ext_q : ext_q;
    end
    for (genvar k = 0; k < NACC; k++) begin : g_acc
      always_comb begin
        acc_d[k] = acc_q[k];
        if (in_valid) acc_d[k] = in_blk ? prod[k] : acc_q[k] + prod[k];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc_q[k] <= '0;
        else if (in_valid) acc_q[k] <= acc_d[k];
      end
      assign rec_in[(NACC-1-k)*ACC_W +: ACC_W] = acc_q[k];
    end
  endgenerate
  assign rec_in[NACC*ACC_W +: TSW] = bstamp_q;

  tc_fifo #(.W(RECW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(rec_in),
    .pop_i(dump_rd), .empty_o(dump_empty), .data_o(rec_out));

  assign dump_stamp = rec_out[NACC*ACC_W +: TSW];
  assign dump_ei    = rec_out[5*ACC_W +: ACC_W];
  assign dump_eq    = rec_out[4*ACC_W +: ACC_W];
  assign dump_pi    = rec_out[3*ACC_W +: ACC_W];
  assign dump_pq    = rec_out[2*ACC_W +: ACC_W];
  assign dump_li    = rec_out[1*ACC_W +: ACC_W];
  assign dump_lq    = rec_out[0 +: ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carr_pend_q <= '0;
      code_pend_q <= '0;
      meas_n_q    <= '0;
      meas_cnt_q  <= '0;
      armed_q     <= 1'b0;
      bstamp_q    <= '0;
      fwd_valid   <= 1'b0;
      fwd_blk     <= 1'b0;
      fwd_stamp   <= '0;
      fwd_i       <= '0;
      fwd_q       <= '0;
      meas_valid  <= 1'b0;
      meas_carr   <= '0;
      meas_code   <= '0;
    end else begin
      carr_pend_q <= carr_pend_d;
      code_pend_q <= code_pend_d;
      meas_n_q    <= meas_n_d;
      meas_cnt_q  <= meas_cnt_d;
      armed_q     <= armed_d;
      bstamp_q    <= bstamp_d;
      fwd_valid   <= in_valid;
      if (in_valid) begin
        fwd_blk   <= in_blk;
        fwd_stamp <= in_stamp;
        fwd_i     <= in_i;
        fwd_q     <= in_q;
      end
      meas_valid  <= meas_hit;
      if (meas_hit) begin
        meas_carr <= carr_phase;
        meas_code <= code_phase;
      end
    end
  end

  // R2: a valid input reappears unchanged one clock later
  p_fwd_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (fwd_valid && fwd_i == $past(in_i) && fwd_q == $past(in_q) &&
                  fwd_blk == $past(in_blk) && fwd_stamp == $past(in_stamp)));
  // R9: a measurement only follows a block marker
  p_meas_on_blk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> $past(in_valid && in_blk));
  // R6: the FIFO only becomes non-empty after a block marker
  p_dump_on_blk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dump_empty && $past(dump_empty)) |-> $past(in_valid && in_blk));
endmodule

// File: tb/sim_tc_track_chan.sv
module sim_tc_track_chan;
  localparam int CLK_P = 10;
  localparam int L     = 15;
  localparam int F     = 4;
  localparam int LIM   = L * 16;
  localparam int HALF  = 8;
  localparam int DEP   = 4;

  logic clk, rst_n, in_valid, in_blk, wr_en, dump_rd;
  logic [15:0] in_stamp;
  logic signed [3:0] in_i, in_q;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic fwd_valid, fwd_blk, dump_empty, meas_valid;
  logic [15:0] fwd_stamp, dump_stamp, meas_carr;
  logic signed [3:0] fwd_i, fwd_q;
  logic signed [15:0] dump_ei, dump_eq, dump_pi, dump_pq, dump_li, dump_lq;
  logic [7:0] meas_code;

  tc_track_chan #(.CODE_LEN(L), .FRAC_W(F), .FIFO_DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blk(in_blk),
    .in_stamp(in_stamp), .in_i(in_i), .in_q(in_q), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .fwd_valid(fwd_valid),
    .fwd_blk(fwd_blk), .fwd_stamp(fwd_stamp), .fwd_i(fwd_i), .fwd_q(fwd_q),
    .dump_rd(dump_rd), .dump_empty(dump_empty), .dump_stamp(dump_stamp),
    .dump_ei(dump_ei), .dump_eq(dump_eq), .dump_pi(dump_pi), .dump_pq(dump_pq),
    .dump_li(dump_li), .dump_lq(dump_lq), .meas_valid(meas_valid),
    .meas_carr(meas_carr), .meas_code(meas_code));

  int checks = 0, errors = 0;
  // reference state
  bit chips [L];
  int mcp = 0, mkp = 0, mco_act = 0, mca_act = 0, mco_pend = 0, mca_pend = 0;
  int mn = 0, mcnt = 0, st_prev = 0, bno = 0;
  bit armed = 0;
  int acc [6];
  int qst [DEP];
  int qacc [DEP][6];
  int qn = 0, qh = 0;
  int unsigned seed = 32'h1234_5678;

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 0;
    case (a)
      0: mca_pend = d;
      1: mco_pend = d;
      3: begin mn = d; mcnt = 0; end
      default: ;
    endcase
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) & 15) - 8;
  endfunction

  task automatic sample(input int si, input int sq, input bit blk);
    int ts, ri, rq, ci, em, ec, ek;
    int idx [3];
    bit emv;
    ts = (bno * 37 + 5) & 16'hffff;
    in_valid = 1; in_blk = blk; in_i = 4'(si); in_q = 4'(sq); in_stamp = 16'(ts);
    emv = 0; ec = 0; ek = 0;
    if (blk) begin
      if (armed && qn < DEP) begin
        em = (qh + qn) % DEP;
        qst[em] = st_prev;
        for (int k = 0; k < 6; k++) qacc[em][k] = acc[k];
        qn++;
      end
      armed = 1; st_prev = ts;
      for (int k = 0; k < 6; k++) acc[k] = 0;
      mca_act = mca_pend; mco_act = mco_pend;
      if (mn != 0) begin
        if (mcnt + 1 >= mn) begin emv = 1; ek = mkp; ec = mcp; mcnt = 0; end
        else mcnt++;
      end
      bno++;
    end
    case (mkp >> 14)
      0: begin ri = si;  rq = sq;  end
      1: begin ri = sq;  rq = -si; end
      2: begin ri = -si; rq = -sq; end
      default: begin ri = -sq; rq = si; end
    endcase
    idx[0] = ((mcp + HALF) % LIM) / 16;
    idx[1] = mcp / 16;
    idx[2] = ((mcp + LIM - HALF) % LIM) / 16;
    for (int t = 0; t < 3; t++) begin
      ci = chips[idx[t]] ? -1 : 1;
      acc[2*t]   += ci * ri;
      acc[2*t+1] += ci * rq;
    end
    mcp = (mcp + mco_act) % LIM;
    mkp = (mkp + mca_act) % 65536;
    @(negedge clk);
    in_valid = 0; in_blk = 0;
    chk(fwd_valid && fwd_blk == blk && int'(fwd_stamp) == ts &&
        int'(fwd_i) == si && int'(fwd_q) == sq, "R2 forwarded sample", int'(fwd_i), si);
    chk(meas_valid == emv, "R9 meas strobe", int'(meas_valid), int'(emv));
    if (emv) begin
      chk(int'(meas_carr) == ek, "R9 meas carrier (R5)", int'(meas_carr), ek);
      chk(int'(meas_code) == ec, "R9 meas code (R3)", int'(meas_code), ec);
    end
  endtask

  // pat 0: prompt replica, 1: extreme constant, 2: pseudo-random
  task automatic send_block(input int n, input int pat, input int mid,
                            input int ncode, input int ncarr);
    int si, sq;
    for (int k = 0; k < n; k++) begin
      if (k == mid) begin hwrite(1, ncode); hwrite(0, ncarr); end
      case (pat)
        0: begin si = chips[mcp / 16] ? -3 : 3; sq = 1; end
        1: begin si = -8; sq = 7; end
        default: begin si = rnd(); sq = rnd(); end
      endcase
      sample(si, sq, k == 0);
    end
  endtask

  task automatic drain(input string tag);
    int got [6];
    while (qn > 0) begin
      chk(!dump_empty, "R8 record present", int'(dump_empty), 0);
      chk(int'(dump_stamp) == qst[qh], "R6 record stamp", int'(dump_stamp), qst[qh]);
      got = '{int'(dump_ei), int'(dump_eq), int'(dump_pi),
              int'(dump_pq), int'(dump_li), int'(dump_lq)};
      for (int k = 0; k < 6; k++)
        chk(got[k] == qacc[qh][k], $sformatf("R6 %s sum %0d (R3 R4 R5)", tag, k),
            got[k], qacc[qh][k]);
      dump_rd = 1;
      @(negedge clk);
      dump_rd = 0;
      qh = (qh + 1) % DEP;
      qn--;
    end
    chk(dump_empty, "R8 empty after drain", int'(dump_empty), 1);
  endtask

  initial begin
    bit [14:0] pattern;
    rst_n = 0; in_valid = 0; in_blk = 0; in_stamp = 0; in_i = 0; in_q = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; dump_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(dump_empty, "R1 dump_empty", int'(dump_empty), 1);
    chk(!fwd_valid, "R1 fwd_valid", int'(fwd_valid), 0);
    chk(!meas_valid, "R1 meas_valid", int'(meas_valid), 0);
    @(negedge clk);

    pattern = 15'b100110101111000;
    for (int k = 0; k < L; k++) begin
      chips[k] = pattern[k];
      hwrite(2, int'(pattern[k]));
    end
    hwrite(1, 8);
    hwrite(0, 0);
    hwrite(3, 2);

    for (int b = 0; b < 3; b++) send_block(30, 0, -1, 0, 0);
    drain("replica");
    chk(qacc[(qh + DEP - 1) % DEP][2] == 90, "R3 prompt peak", qacc[(qh + DEP - 1) % DEP][2], 90);

    for (int b = 0; b < 2; b++) send_block(30, 1, -1, 0, 0);
    drain("constant");

    hwrite(0, 16'h4000);
    for (int b = 0; b < 2; b++) send_block(30, 2, -1, 0, 0);
    drain("rotating");

    send_block(30, 2, 13, 5, 16'h0900);
    for (int b = 0; b < 2; b++) send_block(30, 2, -1, 0, 0);
    drain("R7 mid-block rate");

    hwrite(3, 0);
    for (int b = 0; b < 6; b++) send_block(20, 2, -1, 0, 0);
    chk(qn == DEP, "R8 model kept depth", qn, DEP);
    drain("R8 overflow");

    hwrite(3, 3);
    hwrite(1, 11);
    for (int b = 0; b < 4; b++) send_block(17, 2, -1, 0, 0);
    drain("fractional rate");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule